// File: doc/BRIEF.md
# Interleaved IQ Frequency Shifter

This block accepts a stream of unsigned samples from one converter that takes the in-phase and quadrature channels in turn. Each accepted word is placed on one rail of a complex sample: the word at an even position within the current block goes to I and the word at an odd position goes to Q. The other rail receives zero. The block removes a DC level from the word. That level is the integer mean of every raw word in the previous completed block. It then multiplies the complex sample by a rotating tone. The tone comes from a phase accumulator and a quarter-wave-shifted read of one sine table.

A stream source pushes samples with `in_valid`/`in_ready`. It holds `block_start` high with the first word of a block when it wants to realign the block. The frequency word is sampled together with each accepted word. A downstream stage takes shifted samples with `out_valid`/`out_ready`. The path is a two-stage pipeline with one global stall. A word is accepted whenever `in_ready` is high. `in_ready` is high when the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds and no new word enters.

Top module: `iq_nco_shifter`

## Requirements
- R1: A word at an even position (0, 2, 4, ...) within its block feeds the I rail with zero on Q. A word at an odd position feeds the Q rail with zero on I.
- R2: The DC value subtracted from each word is floor(sum of raw words / BLOCK_LEN) of the last completed block. It is zero until the first block completes. The word that completes a block is still corrected with the older value.
- R3: A PHASE_W-bit accumulator starts at zero after reset. It supplies the current phase to a word and then adds that word's frequency word, wrapping modulo 2^PHASE_W.
- R4: The top LUT_AW phase bits k index a table of trunc(sin(2πk/2^LUT_AW)·(2^15−1)). The real rotation term is the entry at (k + 2^LUT_AW/4) mod 2^LUT_AW. The imaginary term is the negated entry at k.
- R5: out_i = (i·re − q·im) >>> 15 and out_q = (q·re + i·im) >>> 15. Both are formed in 32-bit signed arithmetic and truncated to the low 16 bits.
- R6: An accepted word with `block_start` high is position 0 of a new block. This resets the parity to even and discards the partial sum. The DC value in use is kept.
- R7: After BLOCK_LEN accepted words a block completes by itself. The next word is position 0 of a new block.
- R8: While `out_valid` is high and `out_ready` is low, `out_i`/`out_q` stay unchanged and `in_ready` is low.
- R9: Without a stall, a word accepted at clock edge n appears with `out_valid` high after edge n+1. No output appears without a prior accepted word.
- R10: After reset, `out_valid` is low, `out_i`/`out_q` are zero and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take the offered word |
| in_sample | input | SAMPLE_W | Unsigned converter word |
| block_start | input | 1 | Offered word begins a new block |
| freq_word | input | PHASE_W | Phase step applied after the word's rotation |
| out_valid | output | 1 | Shifted sample present |
| out_ready | input | 1 | Downstream takes the shifted sample |
| out_i | output | OUT_W | Shifted in-phase value, signed |
| out_q | output | OUT_W | Shifted quadrature value, signed |

## Verification
The bench targets several boundaries.

- **Block boundary.** A design that switched to the new DC value one word early would corrupt the last word of each block. A design that kept the running sum across blocks would drift.
- **Mid-block realignment.** If `block_start` were ignored, I and Q would swap for the rest of the block.
- **Phase timing.** The first shift must use phase zero. A design that advanced the phase before use would rotate every sample one step too far.
- **Stall.** A design without output holding would drop or duplicate samples during a stall.
- **Sine table.** Extreme words and phase steps of a half turn, a quarter turn and a single table step test the indexing and the sign of the imaginary term.

// File: rtl/iq_nco_pkg.sv
package iq_nco_pkg;
  localparam int ROT_W = 16;
  localparam real TWO_PI = 6.28318530717958647692;

  typedef struct packed {
    logic signed [ROT_W-1:0] re;
    logic signed [ROT_W-1:0] im;
  } rot_t;
endpackage

// File: rtl/iq_sine_rom.sv
module iq_sine_rom
  import iq_nco_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic [AW-1:0] idx,
  output rot_t          rot
);
  localparam int DEPTH = 1 << AW;
  localparam int QTR   = DEPTH / 4;
  localparam int AMP   = (1 << (ROT_W - 1)) - 1;

  logic signed [ROT_W-1:0] tbl [DEPTH];

  // one entry per phase step, computed at elaboration
  for (genvar k = 0; k < DEPTH; k++) begin : g_tab
    localparam real ANG = TWO_PI * real'(k) / real'(DEPTH);
    assign tbl[k] = ROT_W'($rtoi($sin(ANG) * real'(AMP)));
  end

  logic [AW-1:0] cos_idx;
  assign cos_idx = idx + AW'(QTR);
  assign rot.re  = tbl[cos_idx];
  assign rot.im  = -tbl[idx];
endmodule

// File: rtl/iq_phase_nco.sv
module iq_phase_nco #(
  parameter int PW = 32,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [PW-1:0] freq,
  output logic [AW-1:0] idx
);
  logic [PW-1:0] phase;

  // current phase is used first, then advanced
  assign idx = phase[PW-1 -: AW];

  always_ff @(posedge clk) begin
    if (rst)       phase <= '0;
    else if (step) phase <= phase + freq;
  end
endmodule

// File: rtl/iq_dc_tracker.sv
module iq_dc_tracker #(
  parameter int SAMPLE_W  = 12,
  parameter int BLOCK_LEN = 4000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                take,
  input  logic                first,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                odd,
  output logic [SAMPLE_W-1:0] dc_est
);
  localparam int CNT_W  = $clog2(BLOCK_LEN);
  localparam int SUM_W  = SAMPLE_W + CNT_W;
  localparam int SH     = SUM_W + CNT_W;
  localparam int PROD_W = SUM_W + SH + 1;
  localparam logic [SH:0] RECIP =
    (SH+1)'(((64'd1 << SH) + 64'(BLOCK_LEN - 1)) / 64'(BLOCK_LEN));

  logic [CNT_W-1:0] cnt, cnt_eff;
  logic [SUM_W-1:0] sum, sum_eff, sum_nx;
  logic             last;

  assign cnt_eff = first ? '0 : cnt;
  assign sum_eff = first ? '0 : sum;
  assign sum_nx  = sum_eff + SUM_W'(sample);
  assign last    = (cnt_eff == CNT_W'(BLOCK_LEN - 1));
  assign odd     = cnt_eff[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      sum    <= '0;
      dc_est <= '0;
    end else if (take) begin
      if (last) begin
        cnt    <= '0;
        sum    <= '0;
        dc_est <= SAMPLE_W'((PROD_W'(sum_nx) * PROD_W'(RECIP)) >> SH);
      end else begin
        cnt    <= cnt_eff + CNT_W'(1);
        sum    <= sum_nx;
      end
    end
  end
endmodule

// File: rtl/iq_cmul.sv
module iq_cmul
  import iq_nco_pkg::*;
#(
  parameter int IN_W  = 13,
  parameter int OUT_W = 16,
  parameter int FRAC  = 15
) (
  input  logic signed [IN_W-1:0]  i_in,
  input  logic signed [IN_W-1:0]  q_in,
  input  rot_t                    rot,
  output logic signed [OUT_W-1:0] i_out,
  output logic signed [OUT_W-1:0] q_out
);
  assign i_out = OUT_W'(((32'(i_in) * 32'(rot.re)) - (32'(q_in) * 32'(rot.im))) >>> FRAC);
  assign q_out = OUT_W'(((32'(q_in) * 32'(rot.re)) + (32'(i_in) * 32'(rot.im))) >>> FRAC);
endmodule

// File: rtl/iq_nco_shifter.sv
module iq_nco_shifter
  import iq_nco_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int BLOCK_LEN = 4000,
  parameter int PHASE_W   = 32,
  parameter int LUT_AW    = 11,
  parameter int OUT_W     = 16,
  parameter int FRAC_W    = 15
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [SAMPLE_W-1:0]     in_sample,
  input  logic                    block_start,
  input  logic [PHASE_W-1:0]      freq_word,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_i,
  output logic signed [OUT_W-1:0] out_q
);
  localparam int X_W = SAMPLE_W + 1;

  logic                    adv, take, odd;
  logic [SAMPLE_W-1:0]     dc_est;
  logic [LUT_AW-1:0]       lut_idx;
  rot_t                    rot, s1_rot;
  logic signed [X_W-1:0]   x_val, s1_i, s1_q;
  logic                    s1_v;
  logic signed [OUT_W-1:0] mul_i, mul_q;

  // single global stall for both stages
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign take     = in_valid && adv;
  assign x_val    = $signed({1'b0, in_sample}) - $signed({1'b0, dc_est});

  iq_dc_tracker #(.SAMPLE_W(SAMPLE_W), .BLOCK_LEN(BLOCK_LEN)) u_dc (
    .clk(clk), .rst(rst), .take(take), .first(block_start),
    .sample(in_sample), .odd(odd), .dc_est(dc_est)
  );

  iq_phase_nco #(.PW(PHASE_W), .AW(LUT_AW)) u_nco (
    .clk(clk), .rst(rst), .step(take), .freq(freq_word), .idx(lut_idx)
  );

  iq_sine_rom #(.AW(LUT_AW)) u_rom (
    .idx(lut_idx), .rot(rot)
  );

  iq_cmul #(.IN_W(X_W), .OUT_W(OUT_W), .FRAC(FRAC_W)) u_mul (
    .i_in(s1_i), .q_in(s1_q), .rot(s1_rot), .i_out(mul_i), .q_out(mul_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v      <= 1'b0;
      s1_i      <= '0;
      s1_q      <= '0;
      s1_rot    <= '0;
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else if (adv) begin
      s1_v <= take;
      if (take) begin
        s1_i   <= odd ? '0 : x_val;
        s1_q   <= odd ? x_val : '0;
        s1_rot <= rot;
      end
      out_valid <= s1_v;
      if (s1_v) begin
        out_i <= mul_i;
        out_q <= mul_q;
      end
    end
  end
endmodule

// File: rtl/iq_nco_checker.sv
module iq_nco_checker #(
  parameter int OUT_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [OUT_W-1:0] out_i,
  input logic signed [OUT_W-1:0] out_q
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_i) && $stable(out_q));

  assert_block_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && in_ready) && in_ready |=> out_valid);

  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_ready));

  always @(negedge clk) begin
    if (rst_q) begin
      assert_reset_R10: assert (!out_valid && out_i == '0 && out_q == '0 && in_ready);
    end
  end
endmodule

bind iq_nco_shifter iq_nco_checker #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
);

// File: tb/sim_iq_nco_shifter.sv
`timescale 1ns/1ps
module sim_iq_nco_shifter;
  localparam int BL = 8;
  localparam int NV = 24;
  localparam real TP = 6.28318530717958647692;

  // vector: {block_start, sample[11:0], freq[31:0]}
  localparam logic [44:0] VEC [NV] = '{
    {1'b1, 12'd2048, 32'h0000_0000}, {1'b0, 12'd100,  32'h0000_0000},
    {1'b0, 12'd4095, 32'h1000_0000}, {1'b0, 12'd0,    32'h4000_0000},
    {1'b0, 12'd1500, 32'h8000_0000}, {1'b0, 12'd3000, 32'hC000_0000},
    {1'b0, 12'd777,  32'h0020_0000}, {1'b0, 12'd2222, 32'hFFE0_0000},
    {1'b0, 12'd2000, 32'h1234_5678}, {1'b0, 12'd2100, 32'h0ABC_DEF0},
    {1'b0, 12'd4095, 32'h7FFF_FFFF}, {1'b0, 12'd0,    32'h0000_0001},
    {1'b0, 12'd1000, 32'h4000_0000}, {1'b0, 12'd3333, 32'h2000_0000},
    {1'b0, 12'd1750, 32'hE000_0000}, {1'b0, 12'd2600, 32'h0040_0000},
    {1'b1, 12'd1111, 32'h0000_0000}, {1'b0, 12'd2900, 32'h5555_5555},
    {1'b0, 12'd10,   32'hAAAA_AAAA}, {1'b0, 12'd4000, 32'h0100_0000},
    {1'b0, 12'd2048, 32'hF000_0000}, {1'b0, 12'd512,  32'h3000_0000},
    {1'b0, 12'd3800, 32'h9000_0000}, {1'b0, 12'd1234, 32'h0000_0000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, block_start = 1'b0, out_ready = 1'b1;
  logic [11:0] in_sample = '0;
  logic [31:0] freq_word = '0;
  logic in_ready, out_valid;
  logic signed [15:0] out_i, out_q;

  always #2.5 clk = ~clk;

  iq_nco_shifter #(.BLOCK_LEN(BL)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .block_start(block_start), .freq_word(freq_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
  );

  int checks = 0, failures = 0;
  logic signed [15:0] exp_i [$], exp_q [$];
  string exp_tag [$];
  bit [31:0] m_phase = 0;
  int m_dc = 0, m_sum = 0, m_cnt = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sine(int k);
    return $rtoi($sin(TP * real'(k) / 2048.0) * 32767.0);
  endfunction

  function automatic void model_push(int raw, bit [31:0] f, bit bs, string tag);
    int x, i, q, k, re, im;
    if (bs) begin m_cnt = 0; m_sum = 0; end
    x = raw - m_dc;
    if (m_cnt % 2 == 0) begin i = x; q = 0; end
    else begin i = 0; q = x; end
    k  = int'(m_phase >> 21);
    re = sine((k + 512) % 2048);
    im = -sine(k);
    exp_i.push_back(16'((i * re - q * im) >>> 15));
    exp_q.push_back(16'((q * re + i * im) >>> 15));
    exp_tag.push_back(tag);
    m_phase = m_phase + f;
    m_sum += raw;
    m_cnt++;
    if (m_cnt == BL) begin m_dc = m_sum / BL; m_sum = 0; m_cnt = 0; end
  endfunction

  task automatic send(int raw, bit [31:0] f, bit bs, string tag);
    in_valid = 1'b1; in_sample = 12'(raw); freq_word = f; block_start = bs;
    forever begin
      @(negedge clk);
      if (in_ready) begin model_push(raw, f, bs, tag); break; end
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; block_start = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (exp_i.size() == 0) begin
        check(1'b0, "R9 output without accepted word", 1, 0);
      end else begin
        string t;
        logic signed [15:0] ei, eq;
        ei = exp_i.pop_front(); eq = exp_q.pop_front(); t = exp_tag.pop_front();
        check(out_i == ei, {t, " out_i"}, out_i, ei);
        check(out_q == eq, {t, " out_q"}, out_q, eq);
      end
    end
  end

  task automatic drain();
    for (int n = 0; n < 50 && exp_i.size() != 0; n++) @(posedge clk);
    #1;
    check(exp_i.size() == 0, "R9 all outputs delivered", exp_i.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "WATCHDOG timeout", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic signed [15:0] hi, hq;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R10 in_ready after reset", in_ready, 1);
    check(out_i == 0 && out_q == 0, "R10 outputs zero", out_i, 0);
    @(posedge clk); #1;

    // table: rails, DC of previous block, phase, lut, product, auto block roll
    for (int v = 0; v < NV; v++)
      send(int'(VEC[v][43:32]), VEC[v][31:0], VEC[v][44], "R1 R2 R3 R4 R5 R7");
    drain();

    // R6: realign mid-block
    send(1800, 32'h0300_0000, 1'b1, "R6");
    send(2500, 32'h0300_0000, 1'b0, "R6");
    send(900,  32'h0300_0000, 1'b0, "R6");
    send(3100, 32'h0300_0000, 1'b1, "R6");
    send(400,  32'h0300_0000, 1'b0, "R6");
    drain();

    // R9 latency on idle pipeline
    @(posedge clk); #1;
    send(2750, 32'h0800_0000, 1'b0, "R9");
    check(out_valid == 1'b0, "R9 not yet valid one edge after accept", out_valid, 0);
    @(posedge clk); #1;
    check(out_valid == 1'b1, "R9 valid two edges after accept", out_valid, 1);
    drain();

    // R8 back-pressure
    out_ready = 1'b0;
    send(3900, 32'h1100_0000, 1'b0, "R8");
    send(150,  32'h2200_0000, 1'b0, "R8");
    hi = out_i; hq = out_q;
    check(out_valid == 1'b1, "R8 output pending", out_valid, 1);
    in_valid = 1'b1; in_sample = 12'd2345; freq_word = 32'h3300_0000;
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R8 in_ready low while stalled", in_ready, 0);
      check(out_i == hi && out_q == hq, "R8 output held", out_i, hi);
    end
    @(posedge clk); #1;
    out_ready = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R8 in_ready after release", in_ready, 1);
    model_push(2345, 32'h3300_0000, 1'b0, "R8");
    @(posedge clk); #1;
    in_valid = 1'b0;
    drain();

    // corner words across a full block: extremes and DC update
    for (int n = 0; n < BL + 2; n++)
      send((n % 2 == 0) ? 4095 : 0, 32'h0020_0000, 1'b0, "R2 R7 extremes");
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule